// File: doc/BRIEF.md
# Serial Programming-Mode Entry Key Detector

This block decides when a small controller switches from normal operation into its serial program/verify mode without a high supply voltage. While the active-low reset-control input is held low, it watches a serial data pin on the falling edges of a serial clock. The data is expected to change on rising edges. It collects exactly 32 bits, least significant bit first, and compares them with a fixed 32-bit entry key. On a match, and only if the low-voltage entry enable (a configuration bit) is set, it raises a program-mode flag. While that flag is set, the block holds the rest of the chip in reset and puts the general I/Os into high impedance. On entry it also gives a single-cycle pulse that clears the program address counter.

The mode stays active for as long as the reset-control input stays low. Driving that input high leaves the mode and also clears the partly collected bits, so every new attempt starts from an empty register. All serial inputs are brought into a fast system clock domain through synchronisers. Edges of the serial clock are found by comparing the synchronised value with its value one system cycle earlier.

Top module: `pgm_entry_detect`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `in_prog_mode_o`, `sys_reset_req_o`, `io_hiz_o` and `addr_clear_pulse_o` are all 0.
- R2: With `rst_ctl_n_i` low and `lv_enable_i` high, 32 bits sampled on the falling edges of `sclk_i` and equal to 0x4D434850 set `in_prog_mode_o` to 1. The n-th falling edge (n = 0..31) carries bit n of the key, so bit 0 comes first.
- R3: Any other 32-bit pattern leaves `in_prog_mode_o` at 0. This includes the key sent most significant bit first (which appears as 0x0A12C2B2) and the key with one bit flipped.
- R4: A matching key with `lv_enable_i` at 0 does not enter the mode.
- R5: Only the first 32 falling edges after `rst_ctl_n_i` goes low are compared. Later edges are ignored until `rst_ctl_n_i` has been high again, so a correct key sent after a wrong one does not enter the mode.
- R6: Driving `rst_ctl_n_i` high throws away any partly shifted sequence. A full key sent after the next low phase enters the mode.
- R7: `sys_reset_req_o` and `io_hiz_o` are 1 exactly while `in_prog_mode_o` is 1.
- R8: `addr_clear_pulse_o` is high for exactly one system clock cycle on each entry, in the cycle in which `in_prog_mode_o` rises, and at no other time.
- R9: Once in the mode, `in_prog_mode_o` stays 1 whatever `sclk_i` and `sdat_i` do, as long as `rst_ctl_n_i` stays low. Driving `rst_ctl_n_i` high returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| rst_ctl_n_i | input | 1 | Reset-control pin, active low; held low to enter and stay in the mode |
| sclk_i | input | 1 | Serial clock; data is sampled on its falling edge |
| sdat_i | input | 1 | Serial data, least significant bit first |
| lv_enable_i | input | 1 | Configuration enable for low-voltage entry |
| in_prog_mode_o | output | 1 | Program/verify mode active |
| sys_reset_req_o | output | 1 | Holds the rest of the design in reset |
| io_hiz_o | output | 1 | Puts the general I/Os into high-impedance input mode |
| addr_clear_pulse_o | output | 1 | One-cycle pulse that clears the program address counter |

## Verification
The hardest case to reach is the locked counter. A wrong 32-bit word has already used up the comparison window, and a correct key follows while the reset-control input is still low. This only shows up if both words are sent back to back in one low phase. A second version of this case starts the key in the middle, so that the first 32 edges hold a shifted copy of it. The bench also sends the key in reverse bit order and with single-bit changes, and sends serial clock activity during the mode, to show that nothing but the reset-control input can end it.

// File: rtl/pgm_entry_pkg.sv
package pgm_entry_pkg;

    localparam int KEY_W = 32;
    localparam logic [KEY_W-1:0] ENTRY_KEY = 32'h4D43_4850;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic mode;
        logic rst_req;
        logic hiz;
        logic addr_clr;
    } mode_state_t;

endpackage

// File: rtl/pe_sync.sv
module pe_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pe_key_shift.sv
module pe_key_shift #(
    parameter int KEY_W = 32,
    parameter logic [KEY_W-1:0] KEY = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic fall_i,
    input  logic bit_i,
    output logic match_o
);

    localparam int CNT_W = $clog2(KEY_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(KEY_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(KEY_W - 1);

    typedef struct packed {
        logic [KEY_W-1:0] sr;
        logic [CNT_W-1:0] cnt;
        logic             match;
    } shift_state_t;

    shift_state_t st_d, st_q;
    logic [KEY_W-1:0] shifted;

    always_comb begin
        st_d = st_q;
        st_d.match = 1'b0;
        shifted = {bit_i, st_q.sr[KEY_W-1:1]};
        if (clr_i) begin
            st_d.sr  = '0;
            st_d.cnt = '0;
        end else if (fall_i && (st_q.cnt != CNT_FULL)) begin
            st_d.sr  = shifted;
            st_d.cnt = st_q.cnt + 1'b1;
            if ((st_q.cnt == CNT_LAST) && (shifted == KEY)) begin
                st_d.match = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign match_o = st_q.match;

endmodule

// File: rtl/pe_mode_ctl.sv
module pe_mode_ctl
    import pgm_entry_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_hi_i,
    input  logic match_i,
    input  logic lv_en_i,
    output logic mode_o,
    output logic rst_req_o,
    output logic hiz_o,
    output logic addr_clr_o
);

    mode_state_t ms_d, ms_q;

    always_comb begin
        ms_d = ms_q;
        ms_d.addr_clr = 1'b0;
        if (ctl_hi_i) begin
            ms_d.mode    = 1'b0;
            ms_d.rst_req = 1'b0;
            ms_d.hiz     = 1'b0;
        end else if (match_i && lv_en_i && !ms_q.mode) begin
            ms_d.mode     = 1'b1;
            ms_d.rst_req  = 1'b1;
            ms_d.hiz      = 1'b1;
            ms_d.addr_clr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms_q <= '0;
        end else begin
            ms_q <= ms_d;
        end
    end

    assign mode_o     = ms_q.mode;
    assign rst_req_o  = ms_q.rst_req;
    assign hiz_o      = ms_q.hiz;
    assign addr_clr_o = ms_q.addr_clr;

endmodule

// File: rtl/pgm_entry_detect.sv
module pgm_entry_detect
    import pgm_entry_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rst_ctl_n_i,
    input  logic sclk_i,
    input  logic sdat_i,
    input  logic lv_enable_i,
    output logic in_prog_mode_o,
    output logic sys_reset_req_o,
    output logic io_hiz_o,
    output logic addr_clear_pulse_o
);

    localparam int SYNC_W = 3;
    localparam logic [SYNC_W-1:0] SYNC_RST = 3'b100;

    logic [SYNC_W-1:0] sync_q;
    logic sclk_s, sdat_s, ctl_hi_s;
    logic sclk_prev_d, sclk_prev_q;
    logic sclk_fall;
    logic key_match;

    pe_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({rst_ctl_n_i, sdat_i, sclk_i}),
        .q_o  (sync_q)
    );

    assign sclk_s   = sync_q[0];
    assign sdat_s   = sync_q[1];
    assign ctl_hi_s = sync_q[2];

    always_comb begin
        sclk_prev_d = sclk_s;
        sclk_fall   = sclk_prev_q & ~sclk_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
        end else begin
            sclk_prev_q <= sclk_prev_d;
        end
    end

    pe_key_shift #(
        .KEY_W(KEY_W),
        .KEY  (ENTRY_KEY)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (ctl_hi_s),
        .fall_i (sclk_fall),
        .bit_i  (sdat_s),
        .match_o(key_match)
    );

    pe_mode_ctl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_hi_i  (ctl_hi_s),
        .match_i   (key_match),
        .lv_en_i   (lv_enable_i),
        .mode_o    (in_prog_mode_o),
        .rst_req_o (sys_reset_req_o),
        .hiz_o     (io_hiz_o),
        .addr_clr_o(addr_clear_pulse_o)
    );

endmodule

// File: rtl/pe_entry_chk.sv
module pe_entry_chk (
    input logic clk,
    input logic rst_n,
    input logic lv_enable_i,
    input logic ctl_hi,
    input logic key_match,
    input logic in_prog_mode_o,
    input logic sys_reset_req_o,
    input logic io_hiz_o,
    input logic addr_clear_pulse_o
);

    // R4
    entry_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_prog_mode_o) |-> $past(lv_enable_i));

    // R2
    entry_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_prog_mode_o) |-> $past(key_match));

    // R7
    outputs_track_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_prog_mode_o |-> (sys_reset_req_o && io_hiz_o));

    // R7
    outputs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_prog_mode_o |-> (!sys_reset_req_o && !io_hiz_o));

    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_clear_pulse_o |=> !addr_clear_pulse_o);

    // R8
    pulse_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_prog_mode_o) |-> addr_clear_pulse_o);

    // R8
    pulse_only_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_clear_pulse_o |-> $rose(in_prog_mode_o));

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_prog_mode_o && !ctl_hi) |=> in_prog_mode_o);

    // R9
    exit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_prog_mode_o) |-> $past(ctl_hi));

endmodule

bind pgm_entry_detect pe_entry_chk u_entry_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .lv_enable_i       (lv_enable_i),
    .ctl_hi            (ctl_hi_s),
    .key_match         (key_match),
    .in_prog_mode_o    (in_prog_mode_o),
    .sys_reset_req_o   (sys_reset_req_o),
    .io_hiz_o          (io_hiz_o),
    .addr_clear_pulse_o(addr_clear_pulse_o)
);

// File: tb/tb_pgm_entry_detect.sv
module tb_pgm_entry_detect;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT = 4;
    localparam logic [31:0] KEY = 32'h4D43_4850;
    localparam int WATCHDOG = 200000;

    typedef struct packed {
        logic [31:0] word;
        logic        en;
        logic        exp;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{KEY,                      1'b1, 1'b1},
        '{KEY,                      1'b0, 1'b0},
        '{32'h0A12_C2B2,            1'b1, 1'b0},
        '{KEY ^ 32'h0000_0001,      1'b1, 1'b0},
        '{KEY ^ 32'h8000_0000,      1'b1, 1'b0},
        '{32'h0000_0000,            1'b1, 1'b0},
        '{32'hFFFF_FFFF,            1'b1, 1'b0},
        '{KEY,                      1'b1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_ctl_n = 1'b1;
    logic sclk = 1'b0;
    logic sdat = 1'b0;
    logic lv_en = 1'b1;
    logic mode, rst_req, hiz, aclr;

    int n_chk = 0;
    int n_bad = 0;
    int pulse_cnt = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pgm_entry_detect dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .rst_ctl_n_i       (rst_ctl_n),
        .sclk_i            (sclk),
        .sdat_i            (sdat),
        .lv_enable_i       (lv_en),
        .in_prog_mode_o    (mode),
        .sys_reset_req_o   (rst_req),
        .io_hiz_o          (hiz),
        .addr_clear_pulse_o(aclr)
    );

    always @(negedge clk) if (aclr) pulse_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bits(input logic [31:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b1;
            sdat = w[i];
            wait_clk(HALF_BIT);
            sclk = 1'b0;
            wait_clk(HALF_BIT);
        end
    endtask

    task automatic ctl_release();
        rst_ctl_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic ctl_hold();
        rst_ctl_n = 1'b0;
        wait_clk(6);
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        wait_clk(3);
        // R1: outputs during reset
        chk("R1 mode in reset", 32'(mode), 0);
        chk("R1 outputs in reset", {29'd0, rst_req, hiz, aclr}, 0);
        rst_n = 1'b1;
        wait_clk(2);
        // R1: outputs right after reset release
        chk("R1 mode after reset", 32'(mode), 0);
        chk("R1 outputs after reset", {29'd0, rst_req, hiz, aclr}, 0);

        for (int v = 0; v < NVEC; v++) begin
            lv_en = VECS[v].en;
            ctl_release();
            pulse_cnt = 0;
            ctl_hold();
            send_bits(VECS[v].word, 32);
            wait_clk(8);
            if (VECS[v].exp)
                chk("R2 key entry", 32'(mode), 1);
            else if (VECS[v].en)
                chk("R3 wrong pattern", 32'(mode), 0);
            else
                chk("R4 enable low", 32'(mode), 0);
            chk("R7 reset request", 32'(rst_req), 32'(VECS[v].exp));
            chk("R7 io hiz", 32'(hiz), 32'(VECS[v].exp));
            chk("R8 address clear count", 32'(pulse_cnt), 32'(VECS[v].exp));
            ctl_release();
            chk("R9 exit on release", 32'(mode), 0);
        end
        lv_en = 1'b1;

        // R5: wrong word, then key, same low phase
        pulse_cnt = 0;
        ctl_hold();
        send_bits(32'h0000_0000, 32);
        send_bits(KEY, 32);
        wait_clk(8);
        chk("R5 key after full wrong word", 32'(mode), 0);
        chk("R5 no pulse", 32'(pulse_cnt), 0);
        ctl_release();

        // R5: key shifted by 12 edges inside one low phase
        ctl_hold();
        send_bits(KEY, 12);
        send_bits(KEY, 32);
        wait_clk(8);
        chk("R5 misaligned key", 32'(mode), 0);
        ctl_release();

        // R6: partial then release, then full key
        ctl_hold();
        send_bits(KEY, 20);
        ctl_release();
        pulse_cnt = 0;
        ctl_hold();
        send_bits(KEY, 32);
        wait_clk(8);
        chk("R6 entry after aborted attempt", 32'(mode), 1);
        chk("R8 single pulse", 32'(pulse_cnt), 1);

        // R9: serial activity in mode keeps mode, no new pulse
        send_bits(32'hA5A5_5A5A, 32);
        send_bits(KEY, 32);
        wait_clk(8);
        chk("R9 mode kept under activity", 32'(mode), 1);
        chk("R8 no extra pulse", 32'(pulse_cnt), 1);
        ctl_release();
        chk("R9 exit after activity", 32'(mode), 0);

        // R1: system reset while in mode
        ctl_hold();
        send_bits(KEY, 32);
        wait_clk(8);
        chk("R2 entry before reset", 32'(mode), 1);
        rst_n = 1'b0;
        wait_clk(2);
        chk("R1 reset clears mode", {28'd0, mode, rst_req, hiz, aclr}, 0);
        rst_n = 1'b1;
        wait_clk(4);
        chk("R1 mode stays off after reset", 32'(mode), 0);

        done = 1'b1;
        report();
    end

endmodule